// File: doc/BRIEF.md
# Event-Driven Pattern Sequencer

This block plays stored parallel words out of a pattern memory, one word per clock, under the control of a sequence table. A block is defined by a start address and a length in a block table. Each sequence entry either names one block or calls a subsequence: a short list of blocks that runs as one unit and uses a single entry. An entry repeats a given number of times or forever. It may also be tagged to watch an external event input; when the event has been seen, playback leaves the entry at the end of its current pass and continues at a stored target entry.

A trigger starts playback. The run mode picks one of three behaviours. In repeat, the whole sequence loops. In single, the sequence plays once. In step, the sequencer halts after each entry until the next trigger. A sync marker flags the start of playback and an event marker flags a jump. Both markers lead the first affected data word by one clock. An inhibit input takes every output enable low, which puts the data pads in high impedance. The tables are loaded through plain write ports.

Top module: `psq_top`

## Requirements
- R1: After reset, data_o is all zeros, sync_o and evmark_o are low, and the sequencer is idle until a trigger.
- R2: A trigger seen at a clock edge while idle starts at entry 0. The block's words, from start+0 to start+len-1, appear on data_o one per clock, the first one clock after that edge. An entry with count N>0 plays its block N times and then moves to the next entry, or ends the sequence if its last flag is set. Sequence entry fields from the LSB are: reference (block id or subsequence start), count, jump target, wait flag, last flag, and kind flag (1 = subsequence).
- R3: A block length below MIN_LEN plays as MIN_LEN words.
- R4: A count of 0 repeats without end. A rising edge on event_i, passed through two synchronising flops, is held pending. At the end of a pass of an entry whose wait flag is set, a pending event causes a jump to the entry's target and is consumed. The event marker goes high for 8 clocks, starting one clock before the target's first word.
- R5: A pending event has no effect on an entry without the wait flag. A trigger that starts playback from idle clears any pending event.
- R6: A subsequence entry plays its list of blocks in order, starting at the subsequence table index in its reference field and running up to the element whose last flag is set. One pass of the whole list counts as one repeat. Subsequence element fields from the LSB are: block id, last flag, nest flag.
- R7: A subsequence element whose nest flag is set ends the sequence at once, and data_o keeps its last word.
- R8: Mode encoding is 00 repeat, 01 single, 10 step. The mode is read when the sequence ends. In repeat, playback resumes at entry 0 with no gap. In single, the sequencer goes idle and data_o holds its last word.
- R9: In step mode, the sequencer halts after each change of entry with data_o held. The next trigger resumes play at the new entry without a sync marker.
- R10: sync_o goes high for exactly 6 clocks, starting one clock before the first word of a playback started from idle.
- R11: data_oe_o equals chan_en_i while inhibit_i is low, and is all zeros while inhibit_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Start / step trigger, synchronous |
| mode_i | input | 2 | Run mode: 00 repeat, 01 single, 10 step |
| event_i | input | 1 | External event, asynchronous |
| inhibit_i | input | 1 | Forces all output enables low |
| chan_en_i | input | DW | Per-channel enable |
| data_o | output | DW | Played pattern word |
| data_oe_o | output | DW | Per-channel output enable (low = high impedance) |
| sync_o | output | 1 | Playback start marker |
| evmark_o | output | 1 | Jump marker |
| pat_we_i | input | 1 | Pattern memory write enable |
| pat_waddr_i | input | PAT_AW | Pattern memory write address |
| pat_wdata_i | input | DW | Pattern memory write data |
| blk_we_i | input | 1 | Block table write enable |
| blk_waddr_i | input | BLK_AW | Block id to write |
| blk_wstart_i | input | PAT_AW | Block start address |
| blk_wlen_i | input | PAT_AW+1 | Block length in words |
| seq_we_i | input | 1 | Sequence table write enable |
| seq_waddr_i | input | SEQ_AW | Sequence entry index |
| seq_wdata_i | input | SEQ_W | Sequence entry, layout in R2 |
| sub_we_i | input | 1 | Subsequence table write enable |
| sub_waddr_i | input | SUB_AW | Subsequence element index |
| sub_wdata_i | input | BLK_AW+2 | Subsequence element, layout in R6 |

## Verification
The hardest case to reach from the ports is an event that crosses the synchroniser close to a block boundary. Whether the jump happens at the end of this pass or the next one depends on the exact cycle in which the event becomes pending. The stimulus raises event_i at a known sample index inside an entry that repeats without end. Counting the two synchronising flops and the edge detector, the bench works out which pass boundary is the first to see the pending event. It then checks the word stream and the exact marker cycles. A second run leaves a pending event over from a non-waiting entry, to show that the next trigger clears it.

// File: rtl/psq_pkg.sv
package psq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PLAY = 2'd1,
    ST_HOLD = 2'd2
  } psq_state_e;

  localparam logic [1:0] MODE_REPEAT = 2'b00;
  localparam logic [1:0] MODE_SINGLE = 2'b01;
  localparam logic [1:0] MODE_STEP   = 2'b10;
endpackage

// File: rtl/psq_tables.sv
module psq_tables #(
  parameter int DW     = 12,
  parameter int PAT_AW = 10,
  parameter int BLK_AW = 8,
  parameter int SEQ_AW = 11,
  parameter int SUB_AW = 4,
  parameter int SEQ_W  = 40,
  parameter int SUB_W  = 10,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              pat_we,
  input  logic [PAT_AW-1:0] pat_wa,
  input  logic [DW-1:0]     pat_wd,
  input  logic              blk_we,
  input  logic [BLK_AW-1:0] blk_wa,
  input  logic [PAT_AW-1:0] blk_wstart,
  input  logic [LEN_W-1:0]  blk_wlen,
  input  logic              seq_we,
  input  logic [SEQ_AW-1:0] seq_wa,
  input  logic [SEQ_W-1:0]  seq_wd,
  input  logic              sub_we,
  input  logic [SUB_AW-1:0] sub_wa,
  input  logic [SUB_W-1:0]  sub_wd,
  input  logic [PAT_AW-1:0] pat_ra,
  input  logic [BLK_AW-1:0] blk_ra,
  input  logic [SEQ_AW-1:0] seq_ra,
  input  logic [SUB_AW-1:0] sub_ra,
  output logic [DW-1:0]     pat_rd,
  output logic [PAT_AW-1:0] blk_start,
  output logic [LEN_W-1:0]  blk_len,
  output logic [SEQ_W-1:0]  seq_rd,
  output logic [SUB_W-1:0]  sub_rd
);
  logic [DW-1:0]     pat_mem   [2**PAT_AW];
  logic [PAT_AW-1:0] start_mem [2**BLK_AW];
  logic [LEN_W-1:0]  len_mem   [2**BLK_AW];
  logic [SEQ_W-1:0]  seq_mem   [2**SEQ_AW];
  logic [SUB_W-1:0]  sub_mem   [2**SUB_AW];

  always_ff @(posedge clk) begin
    if (pat_we) pat_mem[pat_wa] <= pat_wd;
    if (blk_we) begin
      start_mem[blk_wa] <= blk_wstart;
      len_mem[blk_wa]   <= blk_wlen;
    end
    if (seq_we) seq_mem[seq_wa] <= seq_wd;
    if (sub_we) sub_mem[sub_wa] <= sub_wd;
  end

  assign pat_rd    = pat_mem[pat_ra];
  assign blk_start = start_mem[blk_ra];
  assign blk_len   = len_mem[blk_ra];
  assign seq_rd    = seq_mem[seq_ra];
  assign sub_rd    = sub_mem[sub_ra];
endmodule

// File: rtl/psq_evsync.sv
module psq_evsync (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_async,
  input  logic clr,
  output logic pend
);
  logic s1, s2, s3, pend_n;

  always_comb begin
    pend_n = pend;
    if (clr)             pend_n = 1'b0;
    else if (s2 && !s3)  pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      s3   <= 1'b0;
      pend <= 1'b0;
    end else begin
      s1   <= ev_async;
      s2   <= s1;
      s3   <= s2;
      pend <= pend_n;
    end
  end
endmodule

// File: rtl/psq_pulse.sv
module psq_pulse #(
  parameter int LEN = 6,
  localparam int CNT_W = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  logic [CNT_W-1:0] cnt, cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (fire)            cnt_n = CNT_W'(LEN);
    else if (cnt != '0)  cnt_n = cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  assign pulse = (cnt != '0);
endmodule

// File: rtl/psq_engine.sv
module psq_engine
  import psq_pkg::*;
#(
  parameter int DW      = 12,
  parameter int PAT_AW  = 10,
  parameter int BLK_AW  = 8,
  parameter int SEQ_AW  = 11,
  parameter int SUB_AW  = 4,
  parameter int CW      = 16,
  parameter int MIN_LEN = 64,
  parameter int REF_W   = 8,
  parameter int SEQ_W   = 40,
  parameter int SUB_W   = 10,
  parameter int LEN_W   = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [1:0]        mode,
  input  logic              ev_pend,
  input  logic [SEQ_W-1:0]  seq_rd,
  input  logic [SUB_W-1:0]  sub_rd,
  input  logic [PAT_AW-1:0] blk_start,
  input  logic [LEN_W-1:0]  blk_len,
  input  logic [DW-1:0]     pat_rd,
  output logic [SEQ_AW-1:0] seq_ra,
  output logic [SUB_AW-1:0] sub_ra,
  output logic [BLK_AW-1:0] blk_ra,
  output logic [PAT_AW-1:0] pat_ra,
  output logic [DW-1:0]     data_q,
  output logic              start_fire,
  output logic              jump_fire,
  output logic              ev_clr,
  output logic              play,
  output logic [LEN_W-1:0]  cur_off,
  output logic [LEN_W-1:0]  cur_len
);
  localparam int CNT_LSB = REF_W;
  localparam int TGT_LSB = CNT_LSB + CW;
  localparam int WT_BIT  = TGT_LSB + SEQ_AW;
  localparam int LST_BIT = WT_BIT + 1;
  localparam int KND_BIT = WT_BIT + 2;

  psq_state_e        st, st_n;
  logic [SEQ_AW-1:0] sidx, sidx_n, tgt;
  logic [CW-1:0]     rep, rep_n;
  logic [SUB_AW-1:0] subpos, subpos_n;
  logic [LEN_W-1:0]  off, off_n;
  logic [DW-1:0]     data_n;
  logic              go_tgt, end_seq;

  logic [REF_W-1:0]  e_ref;
  logic [CW-1:0]     e_cnt;
  logic [SEQ_AW-1:0] e_tgt;
  logic              e_wait, e_last, e_kind;
  logic              s_last, s_nest;

  assign e_ref  = seq_rd[REF_W-1:0];
  assign e_cnt  = seq_rd[CNT_LSB +: CW];
  assign e_tgt  = seq_rd[TGT_LSB +: SEQ_AW];
  assign e_wait = seq_rd[WT_BIT];
  assign e_last = seq_rd[LST_BIT];
  assign e_kind = seq_rd[KND_BIT];
  assign s_last = sub_rd[BLK_AW];
  assign s_nest = sub_rd[BLK_AW+1];

  assign seq_ra  = sidx;
  assign sub_ra  = e_ref[SUB_AW-1:0] + subpos;
  assign blk_ra  = e_kind ? sub_rd[BLK_AW-1:0] : e_ref[BLK_AW-1:0];
  assign cur_len = (blk_len < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : blk_len;
  assign pat_ra  = blk_start + off[PAT_AW-1:0];
  assign cur_off = off;

  always_comb begin
    st_n       = st;
    sidx_n     = sidx;
    rep_n      = rep;
    subpos_n   = subpos;
    off_n      = off;
    start_fire = 1'b0;
    jump_fire  = 1'b0;
    ev_clr     = 1'b0;
    play       = 1'b0;
    go_tgt     = 1'b0;
    end_seq    = 1'b0;
    tgt        = sidx;
    case (st)
      ST_IDLE: if (trig) begin
        st_n       = ST_PLAY;
        sidx_n     = '0;
        rep_n      = '0;
        subpos_n   = '0;
        off_n      = '0;
        start_fire = 1'b1;
        ev_clr     = 1'b1;
      end
      ST_HOLD: if (trig) st_n = ST_PLAY;
      default: begin
        if (e_kind && s_nest) begin
          end_seq = 1'b1;
        end else begin
          play = 1'b1;
          if (off == cur_len - LEN_W'(1)) begin
            off_n = '0;
            if (e_kind && !s_last) begin
              subpos_n = subpos + SUB_AW'(1);
            end else if (e_wait && ev_pend) begin
              jump_fire = 1'b1;
              ev_clr    = 1'b1;
              go_tgt    = 1'b1;
              tgt       = e_tgt;
            end else if (e_cnt != '0 && rep == e_cnt - CW'(1)) begin
              if (e_last) end_seq = 1'b1;
              else begin
                go_tgt = 1'b1;
                tgt    = sidx + SEQ_AW'(1);
              end
            end else begin
              rep_n    = rep + CW'(1);
              subpos_n = '0;
            end
          end else begin
            off_n = off + LEN_W'(1);
          end
        end
        if (go_tgt) begin
          sidx_n   = tgt;
          rep_n    = '0;
          subpos_n = '0;
          if (mode == MODE_STEP) st_n = ST_HOLD;
        end
        if (end_seq) begin
          sidx_n   = '0;
          rep_n    = '0;
          subpos_n = '0;
          off_n    = '0;
          if (mode != MODE_REPEAT) st_n = ST_IDLE;
        end
      end
    endcase
    data_n = play ? pat_rd : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      sidx   <= '0;
      rep    <= '0;
      subpos <= '0;
      off    <= '0;
      data_q <= '0;
    end else begin
      st     <= st_n;
      sidx   <= sidx_n;
      rep    <= rep_n;
      subpos <= subpos_n;
      off    <= off_n;
      data_q <= data_n;
    end
  end
endmodule

// File: rtl/psq_top.sv
module psq_top #(
  parameter int DW       = 12,
  parameter int PAT_AW   = 10,
  parameter int BLK_AW   = 8,
  parameter int SEQ_AW   = 11,
  parameter int SUB_AW   = 4,
  parameter int CW       = 16,
  parameter int MIN_LEN  = 64,
  parameter int SYNC_LEN = 6,
  parameter int EVM_LEN  = 8,
  localparam int REF_W   = (BLK_AW > SUB_AW) ? BLK_AW : SUB_AW,
  localparam int SEQ_W   = REF_W + CW + SEQ_AW + 3,
  localparam int SUB_W   = BLK_AW + 2,
  localparam int LEN_W   = PAT_AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [1:0]        mode_i,
  input  logic              event_i,
  input  logic              inhibit_i,
  input  logic [DW-1:0]     chan_en_i,
  output logic [DW-1:0]     data_o,
  output logic [DW-1:0]     data_oe_o,
  output logic              sync_o,
  output logic              evmark_o,
  input  logic              pat_we_i,
  input  logic [PAT_AW-1:0] pat_waddr_i,
  input  logic [DW-1:0]     pat_wdata_i,
  input  logic              blk_we_i,
  input  logic [BLK_AW-1:0] blk_waddr_i,
  input  logic [PAT_AW-1:0] blk_wstart_i,
  input  logic [LEN_W-1:0]  blk_wlen_i,
  input  logic              seq_we_i,
  input  logic [SEQ_AW-1:0] seq_waddr_i,
  input  logic [SEQ_W-1:0]  seq_wdata_i,
  input  logic              sub_we_i,
  input  logic [SUB_AW-1:0] sub_waddr_i,
  input  logic [SUB_W-1:0]  sub_wdata_i
);
  logic [SEQ_AW-1:0] seq_ra;
  logic [SUB_AW-1:0] sub_ra;
  logic [BLK_AW-1:0] blk_ra;
  logic [PAT_AW-1:0] pat_ra, blk_start;
  logic [LEN_W-1:0]  blk_len, cur_off, cur_len;
  logic [SEQ_W-1:0]  seq_rd;
  logic [SUB_W-1:0]  sub_rd;
  logic [DW-1:0]     pat_rd;
  logic              ev_pend, ev_clr, start_fire, jump_fire, play;

  psq_tables #(
    .DW(DW), .PAT_AW(PAT_AW), .BLK_AW(BLK_AW), .SEQ_AW(SEQ_AW), .SUB_AW(SUB_AW),
    .SEQ_W(SEQ_W), .SUB_W(SUB_W), .LEN_W(LEN_W)
  ) u_tables (
    .clk(clk_i),
    .pat_we(pat_we_i), .pat_wa(pat_waddr_i), .pat_wd(pat_wdata_i),
    .blk_we(blk_we_i), .blk_wa(blk_waddr_i), .blk_wstart(blk_wstart_i), .blk_wlen(blk_wlen_i),
    .seq_we(seq_we_i), .seq_wa(seq_waddr_i), .seq_wd(seq_wdata_i),
    .sub_we(sub_we_i), .sub_wa(sub_waddr_i), .sub_wd(sub_wdata_i),
    .pat_ra(pat_ra), .blk_ra(blk_ra), .seq_ra(seq_ra), .sub_ra(sub_ra),
    .pat_rd(pat_rd), .blk_start(blk_start), .blk_len(blk_len),
    .seq_rd(seq_rd), .sub_rd(sub_rd)
  );

  psq_evsync u_evsync (
    .clk(clk_i), .rst_n(rst_ni), .ev_async(event_i), .clr(ev_clr), .pend(ev_pend)
  );

  psq_engine #(
    .DW(DW), .PAT_AW(PAT_AW), .BLK_AW(BLK_AW), .SEQ_AW(SEQ_AW), .SUB_AW(SUB_AW),
    .CW(CW), .MIN_LEN(MIN_LEN), .REF_W(REF_W), .SEQ_W(SEQ_W), .SUB_W(SUB_W),
    .LEN_W(LEN_W)
  ) u_engine (
    .clk(clk_i), .rst_n(rst_ni), .trig(trig_i), .mode(mode_i), .ev_pend(ev_pend),
    .seq_rd(seq_rd), .sub_rd(sub_rd), .blk_start(blk_start), .blk_len(blk_len),
    .pat_rd(pat_rd), .seq_ra(seq_ra), .sub_ra(sub_ra), .blk_ra(blk_ra),
    .pat_ra(pat_ra), .data_q(data_o), .start_fire(start_fire),
    .jump_fire(jump_fire), .ev_clr(ev_clr), .play(play),
    .cur_off(cur_off), .cur_len(cur_len)
  );

  psq_pulse #(.LEN(SYNC_LEN)) u_sync_pulse (
    .clk(clk_i), .rst_n(rst_ni), .fire(start_fire), .pulse(sync_o)
  );

  psq_pulse #(.LEN(EVM_LEN)) u_evm_pulse (
    .clk(clk_i), .rst_n(rst_ni), .fire(jump_fire), .pulse(evmark_o)
  );

  assign data_oe_o = inhibit_i ? '0 : chan_en_i;
endmodule

// File: rtl/psq_chk.sv
module psq_chk #(
  parameter int LEN_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig,
  input logic             sync,
  input logic             evm,
  input logic             ev_pend,
  input logic             play,
  input logic [LEN_W-1:0] cur_off,
  input logic [LEN_W-1:0] cur_len
);
  logic [3:0] sync_run, evm_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_run <= '0;
      evm_run  <= '0;
    end else begin
      sync_run <= sync ? ((sync_run == 4'hF) ? sync_run : sync_run + 4'd1) : 4'd0;
      evm_run  <= evm  ? ((evm_run  == 4'hF) ? evm_run  : evm_run  + 4'd1) : 4'd0;
    end
  end

  // R10
  sync_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync) |-> (sync_run == 4'd6));

  // R10
  sync_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> $past(trig));

  // R4
  evm_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(evm) |-> (evm_run == 4'd8));

  // R4
  evm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evm) |-> $past(ev_pend));

  // R3
  off_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play |-> (cur_off < cur_len));
endmodule

bind psq_top psq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .trig(trig_i), .sync(sync_o), .evm(evmark_o),
  .ev_pend(ev_pend), .play(play), .cur_off(cur_off), .cur_len(cur_len)
);

// File: tb/psq_top_tb.sv
module psq_top_tb;
  localparam int DW = 12, PAT_AW = 8, BLK_AW = 3, SEQ_AW = 4, SUB_AW = 3, CW = 4;
  localparam int SEQ_W = 3 + CW + SEQ_AW + 3;
  localparam int SUB_W = BLK_AW + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trig = 1'b0, ev = 1'b0, inh = 1'b0;
  logic [1:0] mode = 2'b01;
  logic [DW-1:0] chan_en = '1;
  logic [DW-1:0] data, oe;
  logic sync, evm;
  logic pat_we = 1'b0, blk_we = 1'b0, seq_we = 1'b0, sub_we = 1'b0;
  logic [PAT_AW-1:0] pat_wa = '0, blk_ws = '0;
  logic [DW-1:0] pat_wd = '0;
  logic [BLK_AW-1:0] blk_wa = '0;
  logic [PAT_AW:0] blk_wl = '0;
  logic [SEQ_AW-1:0] seq_wa = '0;
  logic [SEQ_W-1:0] seq_wd = '0;
  logic [SUB_AW-1:0] sub_wa = '0;
  logic [SUB_W-1:0] sub_wd = '0;

  int total = 0, bad = 0;
  logic [DW-1:0] expw [0:63];
  int exp_n = 0;
  logic [DW-1:0] got [0:63];
  logic gsync [0:63];
  logic gevm [0:63];
  logic pre_sync;

  always #10 clk = ~clk;

  psq_top #(
    .DW(DW), .PAT_AW(PAT_AW), .BLK_AW(BLK_AW), .SEQ_AW(SEQ_AW), .SUB_AW(SUB_AW),
    .CW(CW), .MIN_LEN(4), .SYNC_LEN(6), .EVM_LEN(8)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .mode_i(mode), .event_i(ev),
    .inhibit_i(inh), .chan_en_i(chan_en), .data_o(data), .data_oe_o(oe),
    .sync_o(sync), .evmark_o(evm),
    .pat_we_i(pat_we), .pat_waddr_i(pat_wa), .pat_wdata_i(pat_wd),
    .blk_we_i(blk_we), .blk_waddr_i(blk_wa), .blk_wstart_i(blk_ws), .blk_wlen_i(blk_wl),
    .seq_we_i(seq_we), .seq_waddr_i(seq_wa), .seq_wdata_i(seq_wd),
    .sub_we_i(sub_we), .sub_waddr_i(sub_wa), .sub_wdata_i(sub_wd)
  );

  function automatic logic [SEQ_W-1:0] mk(input logic kind, input logic last,
      input logic wt, input int tgt, input int cnt, input int rf);
    mk = {kind, last, wt, SEQ_AW'(tgt), CW'(cnt), 3'(rf)};
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic wr_seq(input int idx, input logic [SEQ_W-1:0] w);
    @(negedge clk); seq_we = 1'b1; seq_wa = SEQ_AW'(idx); seq_wd = w;
    @(negedge clk); seq_we = 1'b0;
  endtask

  task automatic wr_blk(input int id, input int st, input int ln);
    @(negedge clk); blk_we = 1'b1; blk_wa = BLK_AW'(id); blk_ws = PAT_AW'(st); blk_wl = (PAT_AW+1)'(ln);
    @(negedge clk); blk_we = 1'b0;
  endtask

  task automatic wr_sub(input int idx, input int blk, input logic last, input logic nest);
    @(negedge clk); sub_we = 1'b1; sub_wa = SUB_AW'(idx); sub_wd = {nest, last, BLK_AW'(blk)};
    @(negedge clk); sub_we = 1'b0;
  endtask

  task automatic add_blk(input int st, input int ln);
    for (int i = 0; i < ln; i++) begin
      expw[exp_n] = DW'(12'h500 + st + i);
      exp_n++;
    end
  endtask

  task automatic capture(input int n, input int ev_at);
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0; pre_sync = sync;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      got[i] = data; gsync[i] = sync; gevm[i] = evm;
      if (i == ev_at) ev = 1'b1;
    end
    ev = 1'b0;
  endtask

  task automatic check_stream(input string tag, input int n);
    int miss = 0, fi = -1;
    for (int i = 0; i < n; i++) begin
      if (got[i] !== expw[(i < exp_n) ? i : exp_n - 1]) begin
        miss++;
        if (fi < 0) fi = i;
      end
    end
    if (fi < 0) check(1'b1, tag, 0, 0);
    else check(1'b0, $sformatf("%s word %0d", tag, fi), int'(got[fi]),
               int'(expw[(fi < exp_n) ? fi : exp_n - 1]));
  endtask

  task automatic t_reset;
    check(data == '0, "R1 data after reset", int'(data), 0);
    check(!sync, "R1 sync after reset", int'(sync), 0);
    check(!evm, "R1 evmark after reset", int'(evm), 0);
  endtask

  task automatic t_single;
    mode = 2'b01;
    wr_seq(0, mk(0, 0, 0, 0, 2, 0));
    wr_seq(1, mk(0, 1, 0, 0, 1, 1));
    exp_n = 0; add_blk(0, 4); add_blk(0, 4); add_blk(16, 5);
    capture(18, -1);
    check_stream("R2 count two then next entry", 18);
    check(pre_sync, "R10 sync leads first word", int'(pre_sync), 1);
    check(gsync[4] && !gsync[5], "R10 sync width 6", int'({gsync[4], gsync[5]}), 2);
    check_stream("R8 single holds last word", 18);
  endtask

  task automatic t_clamp;
    wr_seq(0, mk(0, 1, 0, 0, 1, 3));
    exp_n = 0; add_blk(48, 4);
    capture(8, -1);
    check_stream("R3 short block clamped to minimum", 8);
  endtask

  task automatic t_sub;
    wr_seq(0, mk(1, 0, 0, 0, 2, 0));
    wr_seq(1, mk(0, 1, 0, 0, 1, 0));
    exp_n = 0; add_blk(32, 4); add_blk(64, 6); add_blk(32, 4); add_blk(64, 6); add_blk(0, 4);
    capture(27, -1);
    check_stream("R6 subsequence pass repeated", 27);
  endtask

  task automatic t_nest;
    wr_seq(0, mk(0, 0, 0, 0, 1, 0));
    wr_seq(1, mk(1, 1, 0, 0, 1, 2));
    exp_n = 0; add_blk(0, 4);
    capture(10, -1);
    check_stream("R7 nested element ends sequence", 10);
  endtask

  task automatic t_repeat;
    logic [DW-1:0] d1;
    mode = 2'b00;
    wr_seq(0, mk(0, 0, 0, 0, 1, 0));
    wr_seq(1, mk(0, 1, 0, 0, 1, 1));
    exp_n = 0;
    for (int k = 0; k < 3; k++) begin add_blk(0, 4); add_blk(16, 5); end
    capture(27, -1);
    check_stream("R8 repeat loops without gap", 27);
    mode = 2'b01;
    repeat (20) @(negedge clk);
    d1 = data;
    repeat (5) @(negedge clk);
    check(d1 == 12'h514 && data == d1, "R8 single at end stops loop", int'(data), 12'h514);
  endtask

  task automatic t_jump;
    int hi = 0;
    wr_seq(0, mk(0, 0, 1, 2, 0, 0));
    wr_seq(1, mk(0, 1, 0, 0, 1, 1));
    wr_seq(2, mk(0, 1, 0, 0, 1, 4));
    exp_n = 0; add_blk(0, 4); add_blk(0, 4); add_blk(0, 4); add_blk(64, 6);
    capture(22, 4);
    check_stream("R4 infinite entry jumps after event", 22);
    check(!gevm[10] && gevm[11], "R4 evmark leads target word", int'({gevm[10], gevm[11]}), 1);
    for (int i = 0; i < 22; i++) if (gevm[i]) hi++;
    check(hi == 8 && !gevm[19], "R4 evmark width 8", hi, 8);
  endtask

  task automatic t_ignore;
    int hi = 0;
    wr_seq(0, mk(0, 0, 0, 2, 2, 0));
    wr_seq(1, mk(0, 1, 0, 0, 1, 1));
    exp_n = 0; add_blk(0, 4); add_blk(0, 4); add_blk(16, 5);
    capture(16, 1);
    check_stream("R5 event ignored without wait flag", 16);
    for (int i = 0; i < 16; i++) if (gevm[i]) hi++;
    check(hi == 0, "R5 no evmark without wait flag", hi, 0);
    wr_seq(0, mk(0, 0, 1, 2, 2, 0));
    capture(16, -1);
    check_stream("R5 trigger clears stale event", 16);
  endtask

  task automatic t_step;
    mode = 2'b10;
    wr_seq(0, mk(0, 0, 0, 0, 1, 0));
    wr_seq(1, mk(0, 1, 0, 0, 1, 1));
    exp_n = 0; add_blk(0, 4);
    capture(9, -1);
    check_stream("R9 step halts after entry", 9);
    exp_n = 0; add_blk(16, 5);
    capture(9, -1);
    check_stream("R9 next trigger plays next entry", 9);
    check(!pre_sync && !gsync[0], "R9 no sync on step resume", int'(pre_sync), 0);
    mode = 2'b01;
  endtask

  task automatic t_inhibit;
    chan_en = 12'hA5F; inh = 1'b0;
    @(negedge clk);
    check(oe == 12'hA5F, "R11 enables follow channel mask", int'(oe), 12'hA5F);
    inh = 1'b1;
    @(negedge clk);
    check(oe == '0, "R11 inhibit forces high impedance", int'(oe), 0);
    inh = 1'b0; chan_en = '1;
  endtask

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    for (int a = 0; a < 256; a++) begin
      @(negedge clk); pat_we = 1'b1; pat_wa = PAT_AW'(a); pat_wd = DW'(12'h500 + a);
    end
    @(negedge clk); pat_we = 1'b0;
    wr_blk(0, 0, 4);
    wr_blk(1, 16, 5);
    wr_blk(2, 32, 4);
    wr_blk(3, 48, 2);
    wr_blk(4, 64, 6);
    wr_sub(0, 2, 1'b0, 1'b0);
    wr_sub(1, 4, 1'b1, 1'b0);
    wr_sub(2, 0, 1'b0, 1'b1);
    t_single;
    t_clamp;
    t_sub;
    t_nest;
    t_repeat;
    t_jump;
    t_ignore;
    t_step;
    t_inhibit;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule